// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address of every beat of one SDRAM read or write burst. A start pulse loads the starting column, the burst-length code, the ordering type and the access direction; from the next cycle the block presents the first column and advances one beat on each cycle in which the step enable is high. The final beat of a fixed-length burst is flagged, and a stop input ends any burst early.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block that holds the starting column. Within that block, the order is either an upward count that wraps at the block boundary or the starting offset XORed with the beat count. A full-page burst counts upward through the whole column range, wrapping at the top, until it is stopped. When single-write mode is enabled, writes are one beat long. A reserved code, or a full-page request with interleaved ordering, is refused and reported on an error output.

Top module: `burst_col_gen`

## Requirements
- R1: Length code `len_code_i` 3'b000, 3'b001, 3'b010 and 3'b011 gives 1, 2, 4 and 8 beats. `last_o` is high exactly on the final beat. A step taken on the final beat drops `valid_o` in the next cycle.
- R2: In a fixed burst of N beats, the column bits above the low log2(N) bits equal those of the starting column on every beat.
- R3: With `interleave_i`=0, beat k has block offset (start offset + k) mod N.
- R4: With `interleave_i`=1, beat k has block offset (start offset XOR k).
- R5: Code 3'b111 with `interleave_i`=0 is a full-page burst. Beat k is (start column + k) mod 2^COL_W, and `last_o` stays low for as long as the burst runs.
- R6: `stop_i` high while `valid_o` is high, with no start in that cycle, makes `valid_o` low in the next cycle, whether or not `step_i` is also high.
- R7: With `write_i`=1 and `single_wr_i`=1 the burst is one beat long, whatever the length code. With `write_i`=0 the programmed length applies.
- R8: A start with code 3'b100, 3'b101 or 3'b110, or with 3'b111 and `interleave_i`=1, makes `err_o` high for the one following cycle. No burst starts. A burst already running keeps its column and continues as if no start had come.
- R9: A valid start shows the starting column with `valid_o` high in the next cycle, and replaces any running burst. When `step_i` is low, the column holds.
- R10: After reset, `valid_o`, `last_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; loads the burst parameters |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 0 = sequential order, 1 = interleaved order |
| write_i | input | 1 | Burst is a write |
| single_wr_i | input | 1 | Single-write mode: writes are one beat long |
| step_i | input | 1 | Advance one beat |
| stop_i | input | 1 | End the running burst |
| col_o | output | COL_W | Current column |
| valid_o | output | 1 | Burst active; `col_o` is meaningful |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Previous start was refused |

## Verification
Any corruption of the beat counter, the latched length mask or the latched start column appears on `col_o` at the very next beat. A wrong mask also shows as a block-boundary crossing or as `last_o` rising on the wrong beat, which leaves `valid_o` high too long or drops it too early. The bench sweeps every starting column for each fixed length and both orderings, with stepping gaps on part of the runs. It also runs a full page across the top of the column range, and covers early stop, restart, single-write mode and refused starts, both while idle and while a burst is running.

// File: rtl/burst_col_pkg.sv
`timescale 1ns/1ps
package burst_col_pkg;
  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;
endpackage

// File: rtl/burst_len_decode.sv
`timescale 1ns/1ps
module burst_len_decode
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [2:0]       code_i,
  input  logic             inter_i,
  input  logic             write_i,
  input  logic             single_wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             bad_o
);
  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    bad_o  = 1'b0;
    unique case (code_i)
      BL_1:    mask_o = '0;
      BL_2:    mask_o = COL_W'(3'd1);
      BL_4:    mask_o = COL_W'(3'd3);
      BL_8:    mask_o = COL_W'(3'd7);
      BL_PAGE: begin
        mask_o = '1;
        full_o = 1'b1;
        bad_o  = inter_i;  // full page is sequential only
      end
      default: bad_o = 1'b1;
    endcase
    if (write_i && single_wr_i) begin
      mask_o = '0;
      full_o = 1'b0;
    end
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
`timescale 1ns/1ps
module burst_beat_ctrl #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             step_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o,
  output logic             last_o
);
  logic             active_q, full_q;
  logic [COL_W-1:0] cnt_q, mask_q;

  assign last_o   = active_q && !full_q && (cnt_q == mask_q);
  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign mask_o   = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      full_q   <= full_i;
      cnt_q    <= '0;
      mask_q   <= mask_i;
    end else if (active_q) begin
      if (stop_i)      active_q <= 1'b0;
      else if (step_i) begin
        if (last_o)    active_q <= 1'b0;
        else           cnt_q    <= cnt_q + 1'b1;  // full page wraps naturally
      end
    end
  end

  a_r1_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && step_i && !load_i) |=> !active_q);
  a_r5_page_no_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && full_q) |-> !last_o);
  a_r6_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && stop_i && !load_i) |=> !active_q);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !step_i && !stop_i && !load_i) |=> (active_q && cnt_q == $past(cnt_q)));
endmodule

// File: rtl/burst_col_map.sv
`timescale 1ns/1ps
module burst_col_map #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             inter_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum, seq_col, xor_col;

  assign sum = base_i + cnt_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    // bits inside the block follow the sum, bits above keep the base
    assign seq_col[i] = mask_i[i] ? sum[i] : base_i[i];
    // count never exceeds the mask, so XOR only touches in-block bits
    assign xor_col[i] = base_i[i] ^ cnt_i[i];
  end

  assign col_o = inter_i ? xor_col : seq_col;
endmodule

// File: rtl/burst_col_gen.sv
`timescale 1ns/1ps
module burst_col_gen #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             write_i,
  input  logic             single_wr_i,
  input  logic             step_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  logic [COL_W-1:0] dec_mask, mask_q, cnt_q, base_q;
  logic             dec_full, dec_bad, load, inter_q, err_q, active;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i      (len_code_i),
    .inter_i     (interleave_i),
    .write_i     (write_i),
    .single_wr_i (single_wr_i),
    .mask_o      (dec_mask),
    .full_o      (dec_full),
    .bad_o       (dec_bad)
  );

  assign load = start_i && !dec_bad;

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .mask_i   (dec_mask),
    .full_i   (dec_full),
    .step_i   (step_i),
    .stop_i   (stop_i),
    .active_o (active),
    .cnt_o    (cnt_q),
    .mask_o   (mask_q),
    .last_o   (last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      inter_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= start_i && dec_bad;
      if (load) begin
        base_q  <= start_col_i;
        inter_q <= interleave_i;
      end
    end
  end

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_i  (base_q),
    .cnt_i   (cnt_q),
    .mask_i  (mask_q),
    .inter_i (inter_q),
    .col_o   (col_o)
  );

  assign valid_o = active;
  assign err_o   = err_q;

  a_r2_block_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && step_i && !stop_i && !start_i && !last_o)
      |=> (((col_o ^ $past(col_o)) & ~mask_q) == '0));
  a_r3_seq_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && step_i && !stop_i && !start_i && !last_o && !inter_q)
      |=> ((col_o & mask_q) == (($past(col_o) + 1'b1) & mask_q)));
  a_r8_err_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$rose(valid_o));
  a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(start_i));
  a_r1_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
endmodule

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;
  localparam int COL_W = 9;
  localparam int COLS  = 1 << COL_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0, interleave_i = 1'b0, write_i = 1'b0, single_wr_i = 1'b0;
  logic             step_i = 1'b0, stop_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, err_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  burst_col_gen #(.COL_W(COL_W)) u_dut (.*);

  task automatic tick; @(posedge clk_i); #1; endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int code, bit inter, int k);
    int len, lo, hi;
    len = 1 << code;
    lo  = s % len;
    hi  = s - lo;
    return inter ? hi + (lo ^ k) : hi + ((lo + k) % len);
  endfunction

  task automatic fire(int s, int code, bit inter, bit wr, bit sw);
    start_col_i = COL_W'(s); len_code_i = 3'(code);
    interleave_i = inter; write_i = wr; single_wr_i = sw;
    start_i = 1'b1; tick; start_i = 1'b0;
  endtask

  task automatic run_fixed(int s, int code, bit inter, bit wr, bit sw, bit gap);
    int n, ec, e;
    ec = (wr && sw) ? 0 : code;
    n  = 1 << ec;
    fire(s, code, inter, wr, sw);
    for (int k = 0; k < n; k++) begin
      e = exp_col(s, ec, inter, k);
      chk(valid_o === 1'b1, "R9 valid", int'(valid_o), 1);
      if (wr && sw) chk(col_o == e, "R7 col", int'(col_o), e);
      else if (inter) chk(col_o == e, "R4 col", int'(col_o), e);
      else chk(col_o == e, "R3 col", int'(col_o), e);
      chk((int'(col_o) >> ec) == (s >> ec), "R2 block", int'(col_o) >> ec, s >> ec);
      chk(last_o == (k == n - 1), "R1 last", int'(last_o), int'(k == n - 1));
      if (gap && (k % 2 == 0)) begin
        step_i = 1'b0; tick;
        chk(col_o == e && valid_o, "R9 hold", int'(col_o), e);
      end
      step_i = 1'b1; tick; step_i = 1'b0;
    end
    chk(valid_o == 1'b0, "R1 end", int'(valid_o), 0);
    chk(last_o == 1'b0, "R1 end last", int'(last_o), 0);
  endtask

  initial begin
    #(150000 * 5);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #7; rst_ni = 1'b1; tick;
    chk(valid_o == 0, "R10 valid", int'(valid_o), 0);
    chk(last_o == 0, "R10 last", int'(last_o), 0);
    chk(err_o == 0, "R10 err", int'(err_o), 0);

    // R1 R2 R3 R4: every start column, each fixed length, both orders
    for (int code = 0; code < 4; code++)
      for (int it = 0; it < 2; it++)
        for (int s = 0; s < COLS; s++)
          run_fixed(s, code, bit'(it), 1'b0, 1'b0, bit'((s >> 1) & 1));

    // R7 single-write mode
    run_fixed(13, 3, 1'b0, 1'b1, 1'b1, 1'b0);
    run_fixed(6, 2, 1'b1, 1'b1, 1'b1, 1'b0);
    run_fixed(6, 2, 1'b0, 1'b0, 1'b1, 1'b0);
    run_fixed(6, 3, 1'b1, 1'b1, 1'b0, 1'b0);

    // R5 full page across the top of the column range, then R6 stop
    fire(500, 7, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 600; k++) begin
      chk(col_o == (500 + k) % COLS, "R5 col", int'(col_o), (500 + k) % COLS);
      chk(last_o == 0 && valid_o == 1, "R5 no last", int'(last_o), 0);
      step_i = 1'b1; tick; step_i = 1'b0;
    end
    stop_i = 1'b1; tick; stop_i = 1'b0;
    chk(valid_o == 0, "R6 page stop", int'(valid_o), 0);

    // R6 stop mid fixed burst, with step in the same cycle
    fire(9, 3, 1'b0, 1'b0, 1'b0);
    step_i = 1'b1; tick; tick;
    chk(col_o == 11, "R3 col", int'(col_o), 11);
    stop_i = 1'b1; tick; stop_i = 1'b0; step_i = 1'b0;
    chk(valid_o == 0, "R6 stop", int'(valid_o), 0);

    // R9 restart replaces running burst
    fire(3, 3, 1'b0, 1'b0, 1'b0);
    step_i = 1'b1; tick; step_i = 1'b0;
    fire(20, 1, 1'b1, 1'b0, 1'b0);
    chk(col_o == 20 && valid_o, "R9 restart", int'(col_o), 20);
    step_i = 1'b1; tick; step_i = 1'b0;
    chk(col_o == 21 && last_o, "R9 restart beat2", int'(col_o), 21);
    step_i = 1'b1; tick; step_i = 1'b0;

    // R8 refused starts while idle
    for (int c = 4; c < 8; c++) begin
      fire(40, c, bit'(c == 7), 1'b0, 1'b0);
      chk(err_o == 1, "R8 err", int'(err_o), 1);
      chk(valid_o == 0, "R8 no start", int'(valid_o), 0);
      tick;
      chk(err_o == 0, "R8 err pulse", int'(err_o), 0);
    end
    // R8 refused start during a burst
    fire(16, 2, 1'b0, 1'b0, 1'b0);
    step_i = 1'b1; tick; step_i = 1'b0;
    fire(100, 5, 1'b0, 1'b0, 1'b0);
    chk(err_o == 1, "R8 err busy", int'(err_o), 1);
    chk(col_o == 17 && valid_o, "R8 burst kept", int'(col_o), 17);
    step_i = 1'b1; tick; step_i = 1'b0;
    chk(col_o == 18 && err_o == 0, "R8 burst continues", int'(col_o), 18);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule